// File: doc/BRIEF.md
# Two-Tier Interrupt Controller

This block gathers interrupt events from many sources and drives a single host interrupt pin. Two groups of sources, the per-pin GPIO events and the per-channel ADC conversion-done events, each have their own enable and status registers. Inside each group the enabled status bits are ORed into one summary bit of the top-level status register. The remaining sources post straight into the top-level status: touch detect, FIFO threshold, FIFO overflow, FIFO full, FIFO empty and temperature. The source events are produced elsewhere and arrive as single-cycle pulses. The FIFO threshold source arrives as a level that stays high while the fill level is at or above the threshold.

A host reaches the registers through a simple synchronous write port and a combinational read port. Status bits are sticky. Writing a 1 to a status bit clears it; writing a 0 leaves it alone. A control register holds three things: a master enable, a choice between level and pulse signalling, and the active polarity of the pin. The pin is registered, so it changes one clock after the status that causes it.

Top module: `irq_two_tier`

## Requirements
- R1: After reset the control register, all enables and both second-tier status registers read 0, and the top-level status reads 0x10 (FIFO empty set). The pin then sits at 1, which is the inactive level for polarity 0.
- R2: An event sets its status bit whether or not the matching enable bit is set.
- R3: Writing 1 to a status bit clears it, and writing 0 to a bit leaves it unchanged. This holds at the top-level status (address 2), the GPIO status (address 4) and the ADC status (address 6).
- R4: If a set event and a write-one-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Top-level bit 7 is the OR of the GPIO status bits that are enabled, and top-level bit 6 is the same OR for the ADC bits. Writing to either summary bit has no effect. A summary bit drops only once every enabled bit beneath it has been cleared.
- R6: Top-level bit 1 (FIFO threshold) sets again at once after a clear while the threshold level input stays high.
- R7: With the master enable (control bit 0) at 0, the pin stays at its inactive level, whatever status is pending.
- R8: In level mode (control bit 1 = 0) the pin is active from the clock after any enabled top-level status bit is set. It goes inactive on the clock after the last such bit clears.
- R9: In pulse mode (control bit 1 = 1), when the masked OR of the enabled top-level bits rises, the pin is active for exactly PULSE_W cycles, starting one clock after the rise. No further pulse comes while the OR stays high.
- R10: Control bit 2 selects the polarity: 1 makes the pin active high, 0 makes it active low.
- R11: Register map on the 3-bit address: 0 control, 1 top-level enable, 2 top-level status, 3 GPIO enable, 4 GPIO status, 5 ADC enable, 6 ADC status. Top-level bit order, from bit 0 up: touch, FIFO threshold, FIFO overflow, FIFO full, FIFO empty, temperature, ADC summary, GPIO summary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| gpio_evt_i | input | NG | Per-pin GPIO event pulses |
| adc_evt_i | input | NA | Per-channel ADC done pulses |
| touch_evt_i | input | 1 | Touch detect pulse |
| fifo_at_th_i | input | 1 | Level: FIFO fill at or above threshold |
| fifo_ovf_evt_i | input | 1 | FIFO overflow pulse |
| fifo_full_evt_i | input | 1 | FIFO full pulse |
| fifo_empty_evt_i | input | 1 | FIFO empty pulse |
| temp_evt_i | input | 1 | Temperature event pulse |
| irq_o | output | 1 | Host interrupt pin |

## Verification
The assertions assume that no reset occurs in the middle of an observed window. They also assume that the control and enable registers are not rewritten in the same cycle as the event whose effect they check; the properties that depend on enables exclude cycles with a write. The stimulus follows these rules. Events and writes are driven on the falling edge and held for one full cycle. Enables are set before events are pulsed. Pulse mode is tested only from a quiet state, so a retrigger in the middle of a pulse never occurs.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL     = 3'd0,
    A_TOP_EN   = 3'd1,
    A_TOP_STA  = 3'd2,
    A_GPIO_EN  = 3'd3,
    A_GPIO_STA = 3'd4,
    A_ADC_EN   = 3'd5,
    A_ADC_STA  = 3'd6
  } reg_addr_e;

  // top-level status bit positions
  localparam int TB_TOUCH = 0;
  localparam int TB_TH    = 1;
  localparam int TB_OVF   = 2;
  localparam int TB_FULL  = 3;
  localparam int TB_EMPTY = 4;
  localparam int TB_TEMP  = 5;
  localparam int TB_ADC   = 6;
  localparam int TB_GPIO  = 7;
  localparam int N_DIRECT = 6;

  localparam logic [N_DIRECT-1:0] DIRECT_RST = 6'h10;

  // control register bit positions
  localparam int CB_GLB   = 0;
  localparam int CB_PULSE = 1;
  localparam int CB_POL   = 2;

  // sticky status with write-one-clear, set dominates
  function automatic logic sticky_next(input logic cur, input logic set,
                                       input logic clr);
    return set | (cur & ~clr);
  endfunction

  // map an internal active flag onto the pin level
  function automatic logic pin_level(input logic active, input logic pol);
    return pol ? active : ~active;
  endfunction

endpackage

// File: rtl/irq_sticky.sv
module irq_sticky #(
  parameter int W = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] sta_o
);
  import irq_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sta_o[i] <= RST[i];
      else        sta_o[i] <= sticky_next(sta_o[i], set_i[i], clr_i[i]);
    end
  end

endmodule

// File: rtl/irq_pin.sv
module irq_pin #(
  parameter int PULSE_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic glb_i,
  input  logic pulse_mode_i,
  input  logic pol_i,
  input  logic req_i,
  output logic rise_o,
  output logic pin_o
);
  import irq_pkg::*;

  localparam int CW = $clog2(PULSE_W + 1);
  localparam logic [CW-1:0] RELOAD = CW'(PULSE_W - 1);

  logic          req_q;
  logic [CW-1:0] cnt_q;
  logic          act_next;

  assign rise_o = req_i & ~req_q;

  always_comb begin
    if (!glb_i)            act_next = 1'b0;
    else if (pulse_mode_i) act_next = rise_o | (cnt_q != '0);
    else                   act_next = req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      cnt_q <= '0;
      pin_o <= 1'b1;
    end else begin
      req_q <= req_i;
      if (!glb_i || !pulse_mode_i) cnt_q <= '0;
      else if (rise_o)             cnt_q <= RELOAD;
      else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
      pin_o <= pin_level(act_next, pol_i);
    end
  end

endmodule

// File: rtl/irq_two_tier.sv
module irq_two_tier #(
  parameter int NG      = 8,
  parameter int NA      = 8,
  parameter int PULSE_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic [NG-1:0] gpio_evt_i,
  input  logic [NA-1:0] adc_evt_i,
  input  logic          touch_evt_i,
  input  logic          fifo_at_th_i,
  input  logic          fifo_ovf_evt_i,
  input  logic          fifo_full_evt_i,
  input  logic          fifo_empty_evt_i,
  input  logic          temp_evt_i,
  output logic          irq_o
);
  import irq_pkg::*;

  // control and enable registers
  logic             ctrl_glb, ctrl_pulse_mode, ctrl_pol;
  logic [REG_W-1:0] top_en;
  logic [NG-1:0]    gpio_en;
  logic [NA-1:0]    adc_en;

  // named internal events
  logic wr_ctrl, wr_top_en, wr_top_sta, wr_gpio_en, wr_gpio_sta;
  logic wr_adc_en, wr_adc_sta;

  assign wr_ctrl     = reg_we && (reg_addr == A_CTRL);
  assign wr_top_en   = reg_we && (reg_addr == A_TOP_EN);
  assign wr_top_sta  = reg_we && (reg_addr == A_TOP_STA);
  assign wr_gpio_en  = reg_we && (reg_addr == A_GPIO_EN);
  assign wr_gpio_sta = reg_we && (reg_addr == A_GPIO_STA);
  assign wr_adc_en   = reg_we && (reg_addr == A_ADC_EN);
  assign wr_adc_sta  = reg_we && (reg_addr == A_ADC_STA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_glb        <= 1'b0;
      ctrl_pulse_mode <= 1'b0;
      ctrl_pol        <= 1'b0;
      top_en          <= '0;
      gpio_en         <= '0;
      adc_en          <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_glb        <= reg_wdata[CB_GLB];
        ctrl_pulse_mode <= reg_wdata[CB_PULSE];
        ctrl_pol        <= reg_wdata[CB_POL];
      end
      if (wr_top_en)  top_en  <= reg_wdata;
      if (wr_gpio_en) gpio_en <= reg_wdata[NG-1:0];
      if (wr_adc_en)  adc_en  <= reg_wdata[NA-1:0];
    end
  end

  // second tier: GPIO and ADC banks
  logic [NG-1:0] gpio_sta, gpio_clr;
  logic [NA-1:0] adc_sta, adc_clr;
  logic          gpio_hit, adc_hit;

  assign gpio_clr = wr_gpio_sta ? reg_wdata[NG-1:0] : '0;
  assign adc_clr  = wr_adc_sta  ? reg_wdata[NA-1:0] : '0;

  irq_sticky #(.W(NG), .RST('0)) u_gpio_bank (
    .clk(clk), .rst_n(rst_n), .set_i(gpio_evt_i), .clr_i(gpio_clr),
    .sta_o(gpio_sta)
  );

  irq_sticky #(.W(NA), .RST('0)) u_adc_bank (
    .clk(clk), .rst_n(rst_n), .set_i(adc_evt_i), .clr_i(adc_clr),
    .sta_o(adc_sta)
  );

  assign gpio_hit = |(gpio_sta & gpio_en);
  assign adc_hit  = |(adc_sta & adc_en);

  // first tier: direct sources
  logic [N_DIRECT-1:0] dir_set, dir_clr, dir_sta;

  always_comb begin
    dir_set           = '0;
    dir_set[TB_TOUCH] = touch_evt_i;
    dir_set[TB_TH]    = fifo_at_th_i;
    dir_set[TB_OVF]   = fifo_ovf_evt_i;
    dir_set[TB_FULL]  = fifo_full_evt_i;
    dir_set[TB_EMPTY] = fifo_empty_evt_i;
    dir_set[TB_TEMP]  = temp_evt_i;
  end

  assign dir_clr = wr_top_sta ? reg_wdata[N_DIRECT-1:0] : '0;

  irq_sticky #(.W(N_DIRECT), .RST(DIRECT_RST)) u_top_bank (
    .clk(clk), .rst_n(rst_n), .set_i(dir_set), .clr_i(dir_clr),
    .sta_o(dir_sta)
  );

  logic [REG_W-1:0] top_sta;
  logic             irq_req, irq_rise;

  assign top_sta = {gpio_hit, adc_hit, dir_sta};
  assign irq_req = ctrl_glb & (|(top_sta & top_en));

  irq_pin #(.PULSE_W(PULSE_W)) u_pin (
    .clk(clk), .rst_n(rst_n), .glb_i(ctrl_glb),
    .pulse_mode_i(ctrl_pulse_mode), .pol_i(ctrl_pol), .req_i(irq_req),
    .rise_o(irq_rise), .pin_o(irq_o)
  );

  // read port
  always_comb begin
    case (reg_addr)
      A_CTRL:     reg_rdata = {5'b0, ctrl_pol, ctrl_pulse_mode, ctrl_glb};
      A_TOP_EN:   reg_rdata = top_en;
      A_TOP_STA:  reg_rdata = top_sta;
      A_GPIO_EN:  reg_rdata = REG_W'(gpio_en);
      A_GPIO_STA: reg_rdata = REG_W'(gpio_sta);
      A_ADC_EN:   reg_rdata = REG_W'(adc_en);
      A_ADC_STA:  reg_rdata = REG_W'(adc_sta);
      default:    reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_two_tier_chk.sv
module irq_two_tier_chk #(
  parameter int NG = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [2:0]    reg_addr,
  input logic [7:0]    reg_wdata,
  input logic [NG-1:0] gpio_evt_i,
  input logic          touch_evt_i,
  input logic          fifo_at_th_i,
  input logic          irq_o,
  input logic          ctrl_glb,
  input logic          ctrl_pulse_mode,
  input logic          ctrl_pol,
  input logic [7:0]    top_en,
  input logic [7:0]    top_sta,
  input logic [NG-1:0] gpio_en,
  input logic [NG-1:0] gpio_sta
);
  import irq_pkg::*;

  // R4: a touch event wins over a same-cycle clear
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    touch_evt_i |=> top_sta[TB_TOUCH]);

  // R6: threshold bit is held while the level input is high
  p_th_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_at_th_i |=> top_sta[TB_TH]);

  // R5: an enabled GPIO event raises the summary bit
  p_gpio_gang_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && (|(gpio_evt_i & gpio_en))) |=> top_sta[TB_GPIO]);

  // R3: written ones clear GPIO status when no event competes
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_GPIO_STA && gpio_evt_i == '0)
      |=> ((gpio_sta & $past(reg_wdata[NG-1:0])) == '0));

  // R7: master enable off keeps the pin inactive
  p_glb_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_glb |=> (irq_o == !$past(ctrl_pol)));

  // R8: level mode follows the enabled status on the next clock
  p_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_glb && !ctrl_pulse_mode && (|(top_sta & top_en)))
      |=> (irq_o == $past(ctrl_pol)));

endmodule

bind irq_two_tier irq_two_tier_chk #(.NG(NG)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .gpio_evt_i(gpio_evt_i), .touch_evt_i(touch_evt_i),
  .fifo_at_th_i(fifo_at_th_i), .irq_o(irq_o), .ctrl_glb(ctrl_glb),
  .ctrl_pulse_mode(ctrl_pulse_mode), .ctrl_pol(ctrl_pol), .top_en(top_en),
  .top_sta(top_sta), .gpio_en(gpio_en), .gpio_sta(gpio_sta)
);

// File: tb/irq_two_tier_tb.sv
module irq_two_tier_tb;
  import irq_pkg::*;

  localparam int NG = 8;
  localparam int NA = 8;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [NG-1:0] gpio_evt = '0;
  logic [NA-1:0] adc_evt = '0;
  logic touch = 1'b0, at_th = 1'b0, ovf = 1'b0, full = 1'b0, empty = 1'b0;
  logic temp = 1'b0;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_two_tier #(.NG(NG), .NA(NA), .PULSE_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gpio_evt_i(gpio_evt),
    .adc_evt_i(adc_evt), .touch_evt_i(touch), .fifo_at_th_i(at_th),
    .fifo_ovf_evt_i(ovf), .fifo_full_evt_i(full), .fifo_empty_evt_i(empty),
    .temp_evt_i(temp), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse_touch();
    @(negedge clk); touch = 1'b1;
    @(negedge clk); touch = 1'b0;
  endtask

  task automatic pulse_gpio(input logic [NG-1:0] v);
    @(negedge clk); gpio_evt = v;
    @(negedge clk); gpio_evt = '0;
  endtask

  task automatic pulse_adc(input logic [NA-1:0] v);
    @(negedge clk); adc_evt = v;
    @(negedge clk); adc_evt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int act_cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, d);     chk("R1 ctrl", d, 8'h00);
    rd(A_TOP_EN, d);   chk("R1 top_en", d, 8'h00);
    rd(A_TOP_STA, d);  chk("R1 top_sta", d, 8'h10);
    rd(A_GPIO_STA, d); chk("R1 gpio_sta", d, 8'h00);
    rd(A_ADC_STA, d);  chk("R1 adc_sta", d, 8'h00);
    chk("R1 pin idle", irq, 1);

    // R11 register map readback
    wr(A_GPIO_EN, 8'hA5); rd(A_GPIO_EN, d); chk("R11 gpio_en", d, 8'hA5);
    wr(A_ADC_EN, 8'h3C);  rd(A_ADC_EN, d);  chk("R11 adc_en", d, 8'h3C);
    wr(A_TOP_EN, 8'h5A);  rd(A_TOP_EN, d);  chk("R11 top_en", d, 8'h5A);
    wr(A_CTRL, 8'h06);    rd(A_CTRL, d);    chk("R11 ctrl", d, 8'h06);
    wr(A_CTRL, 8'h00); wr(A_TOP_EN, 8'h00);
    wr(A_GPIO_EN, 8'h00); wr(A_ADC_EN, 8'h00);

    // R2 set regardless of enable
    pulse_touch();
    rd(A_TOP_STA, d); chk("R2 touch set", d, 8'h11);
    pulse_gpio(8'h81);
    rd(A_GPIO_STA, d); chk("R2 gpio set", d, 8'h81);
    rd(A_TOP_STA, d);  chk("R2 gpio not ganged when disabled", d, 8'h11);

    // R3 write-one-clear
    wr(A_TOP_STA, 8'h00); rd(A_TOP_STA, d); chk("R3 zero no effect", d, 8'h11);
    wr(A_TOP_STA, 8'h01); rd(A_TOP_STA, d); chk("R3 clear touch", d, 8'h10);
    wr(A_TOP_STA, 8'h10); rd(A_TOP_STA, d); chk("R3 clear empty", d, 8'h00);
    wr(A_GPIO_STA, 8'h01); rd(A_GPIO_STA, d); chk("R3 gpio partial", d, 8'h80);
    wr(A_GPIO_STA, 8'h80); rd(A_GPIO_STA, d); chk("R3 gpio clear", d, 8'h00);
    pulse_adc(8'h0F);
    wr(A_ADC_STA, 8'h05); rd(A_ADC_STA, d); chk("R3 adc partial", d, 8'h0A);
    wr(A_ADC_STA, 8'hFF);

    // R4 set wins over same-cycle clear
    @(negedge clk);
    touch = 1'b1; reg_we = 1'b1; reg_addr = A_TOP_STA; reg_wdata = 8'h01;
    @(negedge clk);
    touch = 1'b0; reg_we = 1'b0;
    rd(A_TOP_STA, d); chk("R4 set wins", d, 8'h01);
    wr(A_TOP_STA, 8'h01);

    // R6 threshold re-asserts while level holds
    @(negedge clk); at_th = 1'b1;
    @(negedge clk);
    wr(A_TOP_STA, 8'h02); rd(A_TOP_STA, d); chk("R6 held", d, 8'h02);
    at_th = 1'b0;
    wr(A_TOP_STA, 8'h02); rd(A_TOP_STA, d); chk("R6 released", d, 8'h00);

    // R5 sweep of GPIO and ADC enable masks
    for (int en = 0; en < 256; en++) begin
      logic [7:0] p;
      p = 8'((en * 37 + 11) & 255);
      wr(A_GPIO_EN, 8'(en));
      wr(A_ADC_EN, 8'(255 - en));
      pulse_gpio(p);
      pulse_adc(~p);
      rd(A_TOP_STA, d);
      chk("R5 gpio summary", d[7], |(p & 8'(en)));
      chk("R5 adc summary", d[6], |(~p & 8'(255 - en)));
      wr(A_GPIO_STA, 8'hFF);
      wr(A_ADC_STA, 8'hFF);
    end
    wr(A_GPIO_EN, 8'h03);
    pulse_gpio(8'h03);
    wr(A_TOP_STA, 8'h80); rd(A_TOP_STA, d); chk("R5 summary write ignored", d, 8'h80);
    wr(A_GPIO_STA, 8'h01); rd(A_TOP_STA, d); chk("R5 one left", d, 8'h80);
    wr(A_GPIO_STA, 8'h02); rd(A_TOP_STA, d); chk("R5 all cleared", d, 8'h00);
    wr(A_GPIO_EN, 8'h00); wr(A_ADC_EN, 8'h00);

    // R8 level mode, active low
    wr(A_TOP_EN, 8'h01);
    wr(A_CTRL, 8'h01);
    pulse_touch();
    chk("R8 pin not yet", irq, 1);
    @(negedge clk); chk("R8 pin asserted low", irq, 0);
    wr(A_TOP_STA, 8'h01);
    chk("R8 pin still active at clear", irq, 0);
    @(negedge clk); chk("R8 pin released", irq, 1);

    // R10 polarity high
    wr(A_CTRL, 8'h05);
    @(negedge clk); chk("R10 idle low", irq, 0);
    pulse_touch();
    @(negedge clk); chk("R10 active high", irq, 1);

    // R7 master enable off
    wr(A_CTRL, 8'h04);
    repeat (2) @(negedge clk); chk("R7 off pol high", irq, 0);
    wr(A_CTRL, 8'h00);
    pulse_touch();
    repeat (2) @(negedge clk); chk("R7 off pol low", irq, 1);
    wr(A_TOP_STA, 8'h01);

    // R9 pulse mode
    wr(A_CTRL, 8'h07);
    repeat (2) @(negedge clk); chk("R9 quiet", irq, 0);
    pulse_touch();
    act_cnt = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i == 0) chk("R9 first cycle", irq, 1);
      if (irq) act_cnt++;
    end
    chk("R9 pulse width", act_cnt, PW);
    act_cnt = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (irq) act_cnt++;
    end
    chk("R9 no repeat while high", act_cnt, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule